// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block turns one programmed host command into the ordered list of byte operations it needs on a two-wire bus. Software-facing registers are held outside the block. On a start pulse the block captures the address byte, the command byte, two data bytes and a three-bit protocol code. It then drives a byte-level bus engine through a request/done handshake. Each engine operation reports ack or nack. Bytes returned by read forms are written into the block's own data registers.

Completion and failure are reported in a small sticky status word. This word also carries the two flags that mark an I2C-style block read waiting with the bus still held after its first byte. A device error that is already pending blocks further bus traffic until it is cleared. A nack during an address or data phase makes the block close the bus with a stop and give up.

Top module: `smbus_host_seq`

## Requirements
- R1: After reset, `sts`, `data0_q`, `data1_q` and `blk_q` are zero, and `busy` and `eng_req` are low.
- R2: `eng_req` stays high, with `eng_op` and `eng_byte` unchanged, until the cycle in which `eng_done` is high. Engine operation codes are 0 start (the byte is the address byte, with bit 0 as the read flag and bits 7:1 as the target), 1 send byte, 2 receive with ack, 3 receive with nack, and 4 stop.
- R3: `prot_sel` selects the form: 0 quick, 1 byte, 2 byte-data, 3 word-data, 6 I2C block read. The codes 4, 5 and 7 set the device-error bit and perform no engine operation.
- R4: A quick command is start(address byte), stop. A byte write is start, send(command), stop. A byte read is start(address byte), receive-nack into data0, stop.
- R5: A byte-data write is start(addr with bit 0 cleared), send(command), send(data0), stop. A word write sends data0 and then data1 after the command.
- R6: Byte-data and word reads send the command, then issue a repeated start with the read bit set. A byte-data read puts its result in data0. A word read puts the low byte in data0 and the high byte in data1.
- R7: Status bits are 0 done/interrupt, 1 device error, 2 host busy and 3 byte done. A command that completes its final stop without a nack sets bit 0.
- R8: A nack on a start or send makes the very next engine request a stop and sets the device-error bit, not bit 0. `busy` falls on the cycle after that stop is acknowledged.
- R9: If the device-error bit is set when a start is accepted, no engine operation is issued and the bit stays set.
- R10: An I2C block read ignores the read flag. It does start(addr, write), send(data1) and start(addr, read), then a receive-with-ack into `blk_q`. It then sets host busy and byte done, returns to idle with no stop, and leaves the bus held.
- R11: A start accepted while the bus is held first issues a stop and clears host busy, then runs the new command.
- R12: A start pulse while `busy` is high is ignored.
- R13: `sts_clr` clears status bits where it is 1, except bit 2 (host busy), which it cannot clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle command launch |
| prot_sel | input | 3 | Protocol code |
| addr_byte | input | 8 | Target address (7:1) and read flag (0) |
| cmd_byte | input | 8 | Command byte |
| data0_in | input | 8 | Data byte 0 captured at start |
| data1_in | input | 8 | Data byte 1 captured at start |
| sts_clr | input | 4 | Write-one-to-clear mask for the status word |
| busy | output | 1 | Sequencer not idle |
| sts | output | 4 | Status word |
| data0_q | output | 8 | Data register 0 |
| data1_q | output | 8 | Data register 1 |
| blk_q | output | 8 | Block data register |
| eng_req | output | 1 | Engine request |
| eng_op | output | 3 | Engine operation code |
| eng_byte | output | 8 | Byte for start or send |
| eng_done | input | 1 | Engine finished the current operation |
| eng_nack | input | 1 | Target did not acknowledge (valid with done) |
| eng_rdata | input | 8 | Received byte (valid with done) |

## Verification
The hardest states to reach are the held bus left behind by a block read and a nack that arrives in the middle of a command. Neither can be forced from the register inputs alone. The bench's engine model therefore takes a programmable nack position and a programmable response latency. A block read is followed directly by a second command, so the closing stop appears at the head of the next trace. A long latency also keeps the block busy long enough to inject a second start in the middle of a command.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int STS_W  = 4;

  localparam int STS_DONE  = 0;
  localparam int STS_DERR  = 1;
  localparam int STS_HBUSY = 2;
  localparam int STS_BDONE = 3;
  localparam logic [STS_W-1:0] STS_SW_PROTECT = STS_W'(1) << STS_HBUSY;

  localparam logic [2:0] PR_QUICK  = 3'd0;
  localparam logic [2:0] PR_BYTE   = 3'd1;
  localparam logic [2:0] PR_BDATA  = 3'd2;
  localparam logic [2:0] PR_WORD   = 3'd3;
  localparam logic [2:0] PR_I2CBLK = 3'd6;

  typedef enum logic [2:0] {
    OP_START     = 3'd0,
    OP_SEND      = 3'd1,
    OP_RECV      = 3'd2,
    OP_RECV_LAST = 3'd3,
    OP_STOP      = 3'd4,
    OP_HOLD      = 3'd5
  } eng_op_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_ADDR_RW, SRC_ADDR_WR, SRC_ADDR_RD, SRC_CMD, SRC_D0, SRC_D1
  } src_e;

  typedef enum logic [1:0] {DST_NONE, DST_D0, DST_D1, DST_BLK} dst_e;

  typedef struct packed {
    eng_op_e op;
    src_e    src;
    dst_e    dst;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRESTOP, ST_DECIDE, ST_LOAD, ST_ISSUE, ST_ABORT
  } seq_state_e;
endpackage

// File: rtl/smbus_step_rom.sv
module smbus_step_rom
  import smbus_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [2:0]        prot,
  input  logic              rd,
  input  logic [STEP_W-1:0] idx,
  output step_t             step,
  output logic              prot_ok
);
  function automatic step_t mk(eng_op_e o, src_e s, dst_e d);
    step_t r;
    r.op  = o;
    r.src = s;
    r.dst = d;
    return r;
  endfunction

  always_comb begin
    step    = mk(OP_STOP, SRC_NONE, DST_NONE);
    prot_ok = 1'b1;
    case (prot)
      PR_QUICK: begin
        if (int'(idx) == 0) step = mk(OP_START, SRC_ADDR_RW, DST_NONE);
      end
      PR_BYTE: begin
        case (int'(idx))
          0: step = mk(OP_START, SRC_ADDR_RW, DST_NONE);
          1: step = rd ? mk(OP_RECV_LAST, SRC_NONE, DST_D0)
                       : mk(OP_SEND, SRC_CMD, DST_NONE);
          default: ;
        endcase
      end
      PR_BDATA: begin
        case (int'(idx))
          0: step = mk(OP_START, SRC_ADDR_WR, DST_NONE);
          1: step = mk(OP_SEND, SRC_CMD, DST_NONE);
          2: step = rd ? mk(OP_START, SRC_ADDR_RD, DST_NONE)
                       : mk(OP_SEND, SRC_D0, DST_NONE);
          3: if (rd) step = mk(OP_RECV_LAST, SRC_NONE, DST_D0);
          default: ;
        endcase
      end
      PR_WORD: begin
        case (int'(idx))
          0: step = mk(OP_START, SRC_ADDR_WR, DST_NONE);
          1: step = mk(OP_SEND, SRC_CMD, DST_NONE);
          2: step = rd ? mk(OP_START, SRC_ADDR_RD, DST_NONE)
                       : mk(OP_SEND, SRC_D0, DST_NONE);
          3: step = rd ? mk(OP_RECV, SRC_NONE, DST_D0)
                       : mk(OP_SEND, SRC_D1, DST_NONE);
          4: if (rd) step = mk(OP_RECV_LAST, SRC_NONE, DST_D1);
          default: ;
        endcase
      end
      PR_I2CBLK: begin
        // read flag deliberately ignored (R10)
        case (int'(idx))
          0: step = mk(OP_START, SRC_ADDR_WR, DST_NONE);
          1: step = mk(OP_SEND, SRC_D1, DST_NONE);
          2: step = mk(OP_START, SRC_ADDR_RD, DST_NONE);
          3: step = mk(OP_RECV, SRC_NONE, DST_BLK);
          default: step = mk(OP_HOLD, SRC_NONE, DST_NONE);
        endcase
      end
      default: prot_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/smbus_status.sv
module smbus_status
  import smbus_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_W-1:0] hw_set,
  input  logic [STS_W-1:0] hw_clr,
  input  logic [STS_W-1:0] sw_clr,
  output logic [STS_W-1:0] sts
);
  logic [STS_W-1:0] clr_eff;

  assign clr_eff = (sw_clr & ~STS_SW_PROTECT) | hw_clr;

  always_ff @(posedge clk) begin
    if (rst) sts <= '0;
    else     sts <= (sts & ~clr_eff) | hw_set;
  end
endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
  import smbus_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        prot_sel,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [BYTE_W-1:0] data0_in,
  input  logic [BYTE_W-1:0] data1_in,
  input  logic [STS_W-1:0]  sts_clr,
  output logic              busy,
  output logic [STS_W-1:0]  sts,
  output logic [BYTE_W-1:0] data0_q,
  output logic [BYTE_W-1:0] data1_q,
  output logic [BYTE_W-1:0] blk_q,
  output logic              eng_req,
  output logic [2:0]        eng_op,
  output logic [BYTE_W-1:0] eng_byte,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [BYTE_W-1:0] eng_rdata
);
  seq_state_e        state;
  logic [STEP_W-1:0] idx;
  logic [2:0]        prot_r;
  logic [BYTE_W-1:0] addr_r, cmd_r, d0_r, d1_r, blk_r;
  logic              open_rd;
  logic              req_r;
  eng_op_e           op_r;
  logic [BYTE_W-1:0] byte_r;

  step_t             step;
  logic              prot_ok;
  logic [BYTE_W-1:0] src_byte;
  logic [STS_W-1:0]  sts_set, sts_hclr;
  logic              run_err, phase_nack, op_is_tx;

  smbus_step_rom #(.STEP_W(STEP_W)) u_rom (
    .prot    (prot_r),
    .rd      (addr_r[0]),
    .idx     (idx),
    .step    (step),
    .prot_ok (prot_ok)
  );

  smbus_status u_sts (
    .clk    (clk),
    .rst    (rst),
    .hw_set (sts_set),
    .hw_clr (sts_hclr),
    .sw_clr (sts_clr),
    .sts    (sts)
  );

  always_comb begin
    case (step.src)
      SRC_ADDR_RW: src_byte = addr_r;
      SRC_ADDR_WR: src_byte = {addr_r[BYTE_W-1:1], 1'b0};
      SRC_ADDR_RD: src_byte = {addr_r[BYTE_W-1:1], 1'b1};
      SRC_CMD:     src_byte = cmd_r;
      SRC_D0:      src_byte = d0_r;
      SRC_D1:      src_byte = d1_r;
      default:     src_byte = '0;
    endcase
  end

  assign run_err    = sts[STS_DERR] || !prot_ok;
  assign op_is_tx   = (op_r == OP_START) || (op_r == OP_SEND);
  assign phase_nack = eng_done && eng_nack && op_is_tx;

  always_comb begin
    sts_set  = '0;
    sts_hclr = '0;
    case (state)
      ST_DECIDE: begin
        if (run_err) sts_set[STS_DERR]  = 1'b1;
        else         sts_set[STS_HBUSY] = 1'b1;
      end
      ST_LOAD: begin
        if (step.op == OP_HOLD) sts_set[STS_BDONE] = 1'b1;
      end
      ST_ISSUE: begin
        if (phase_nack) begin
          sts_set[STS_DERR] = 1'b1;
        end else if (eng_done && op_r == OP_STOP) begin
          sts_set[STS_DONE]   = 1'b1;
          sts_hclr[STS_HBUSY] = 1'b1;
        end
      end
      ST_ABORT, ST_PRESTOP: begin
        if (eng_done) sts_hclr[STS_HBUSY] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      prot_r  <= '0;
      addr_r  <= '0;
      cmd_r   <= '0;
      d0_r    <= '0;
      d1_r    <= '0;
      blk_r   <= '0;
      open_rd <= 1'b0;
      req_r   <= 1'b0;
      op_r    <= OP_STOP;
      byte_r  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            prot_r <= prot_sel;
            addr_r <= addr_byte;
            cmd_r  <= cmd_byte;
            d0_r   <= data0_in;
            d1_r   <= data1_in;
            idx    <= '0;
            if (open_rd) begin
              req_r  <= 1'b1;
              op_r   <= OP_STOP;
              byte_r <= '0;
              state  <= ST_PRESTOP;
            end else begin
              state  <= ST_DECIDE;
            end
          end
        end
        ST_PRESTOP: begin
          if (eng_done) begin
            req_r   <= 1'b0;
            open_rd <= 1'b0;
            state   <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          state <= run_err ? ST_IDLE : ST_LOAD;
        end
        ST_LOAD: begin
          if (step.op == OP_HOLD) begin
            open_rd <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            req_r  <= 1'b1;
            op_r   <= step.op;
            byte_r <= src_byte;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (eng_done) begin
            if (phase_nack) begin
              op_r   <= OP_STOP;
              byte_r <= '0;
              state  <= ST_ABORT;
            end else begin
              req_r <= 1'b0;
              case (step.dst)
                DST_D0:  d0_r  <= eng_rdata;
                DST_D1:  d1_r  <= eng_rdata;
                DST_BLK: blk_r <= eng_rdata;
                default: ;
              endcase
              if (op_r == OP_STOP) begin
                state <= ST_IDLE;
              end else begin
                idx   <= idx + 1'b1;
                state <= ST_LOAD;
              end
            end
          end
        end
        ST_ABORT: begin
          if (eng_done) begin
            req_r <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign data0_q  = d0_r;
  assign data1_q  = d1_r;
  assign blk_q    = blk_r;
  assign eng_req  = req_r;
  assign eng_op   = op_r;
  assign eng_byte = byte_r;
endmodule

// File: rtl/smbus_host_seq_chk.sv
module smbus_host_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [3:0] sts,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic [7:0] eng_byte,
  input logic       eng_done,
  input logic       eng_nack
);
  // R2
  req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !eng_req);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));

  // R8
  nack_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done && eng_nack && (eng_op == 3'd0 || eng_op == 3'd1))
      |=> (eng_req && eng_op == 3'd4 && sts[1]));

  // R7
  done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[0]) |-> ($past(eng_op) == 3'd4 && $past(eng_done) && !$past(eng_nack)));

  // R10
  hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[3]) |-> sts[2]);
endmodule

bind smbus_host_seq smbus_host_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .sts      (sts),
  .eng_req  (eng_req),
  .eng_op   (eng_op),
  .eng_byte (eng_byte),
  .eng_done (eng_done),
  .eng_nack (eng_nack)
);

// File: tb/smbus_host_seq_tb.sv
module smbus_host_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] prot_sel = '0;
  logic [7:0] addr_byte = '0, cmd_byte = 8'h33, data0_in = 8'h11, data1_in = 8'h22;
  logic [3:0] sts_clr = '0;
  logic       busy;
  logic [3:0] sts;
  logic [7:0] data0_q, data1_q, blk_q;
  logic       eng_req;
  logic [2:0] eng_op;
  logic [7:0] eng_byte;
  logic       eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0] eng_rdata = '0;

  int errors = 0, checks = 0, cyc = 0;
  int lat = 1, nack_idx = -1, cnt = 0, n_log = 0;
  logic [7:0] rcnt = '0;
  logic       log_rst = 1'b0;
  logic [2:0] log_op [0:15];
  logic [7:0] log_byte [0:15];

  always #2.5 clk = ~clk;

  smbus_host_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .prot_sel(prot_sel),
    .addr_byte(addr_byte), .cmd_byte(cmd_byte), .data0_in(data0_in),
    .data1_in(data1_in), .sts_clr(sts_clr), .busy(busy), .sts(sts),
    .data0_q(data0_q), .data1_q(data1_q), .blk_q(blk_q),
    .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
  );

  // engine model
  always @(posedge clk) begin
    if (rst || log_rst) begin
      n_log <= 0; eng_done <= 1'b0; eng_nack <= 1'b0; cnt <= 0; rcnt <= '0;
    end else begin
      eng_done <= 1'b0;
      eng_nack <= 1'b0;
      if (eng_req && !eng_done) begin
        if (cnt >= lat) begin
          cnt      <= 0;
          eng_done <= 1'b1;
          eng_nack <= (n_log == nack_idx);
          if (n_log < 16) begin
            log_op[n_log[3:0]]   <= eng_op;
            log_byte[n_log[3:0]] <= eng_byte;
          end
          n_log <= n_log + 1;
          if (eng_op == 3'd2 || eng_op == 3'd3) begin
            eng_rdata <= 8'h5A + rcnt;
            rcnt      <= rcnt + 8'd1;
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired act=running exp=finished");
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    log_rst = 1'b1; sts_clr = 4'hF;
    @(negedge clk);
    log_rst = 1'b0; sts_clr = 4'h0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    if (busy) chk("R2 stuck busy", 1, 0);
  endtask

  task automatic run(input logic [2:0] p, input logic [7:0] a);
    @(negedge clk);
    prot_sel = p; addr_byte = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  // {prot, addr, n_ops, sts, data0, data1}
  localparam logic [35:0] VEC [0:10] = '{
    36'h0A0211122, 36'h0A1211122, 36'h1A0311122, 36'h1A1315A22,
    36'h2A0411122, 36'h2A1515A22, 36'h3A0511122, 36'h3A1615A5B,
    36'h4A0021122, 36'h5A1021122, 36'h7A0021122
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sts", sts, 0);
    chk("R1 busy", busy, 0);
    chk("R1 eng_req", eng_req, 0);
    chk("R1 data0", data0_q, 0);
    chk("R1 blk", blk_q, 0);
    rst = 1'b0;

    // table: R3 R4 R5 R6 R7
    for (int i = 0; i < 11; i++) begin
      logic [35:0] v;
      v = VEC[i];
      prep();
      run(v[34:32], v[31:24]);
      chk("R3 R4 R5 R6 op count", n_log, v[23:20]);
      chk("R7 R3 status", sts, v[19:16]);
      chk("R6 data0", data0_q, v[15:8]);
      chk("R6 data1", data1_q, v[7:0]);
    end

    // R5 R2 word write trace
    prep();
    run(3'd3, 8'hA0);
    chk("R2 op0 start", log_op[0], 0);
    chk("R2 start byte", log_byte[0], 8'hA0);
    chk("R5 cmd", log_byte[1], 8'h33);
    chk("R5 low first", log_byte[2], 8'h11);
    chk("R5 high second", log_byte[3], 8'h22);
    chk("R5 stop", log_op[4], 4);

    // R6 word read trace: repeated start with read bit
    prep();
    run(3'd3, 8'hA1);
    chk("R6 first start write", log_byte[0], 8'hA0);
    chk("R6 rep start read", log_byte[2], 8'hA1);
    chk("R6 recv ack", log_op[3], 2);
    chk("R4 recv nack last", log_op[4], 3);

    // R8 nack on command send
    prep();
    nack_idx = 1;
    run(3'd2, 8'hA0);
    nack_idx = -1;
    chk("R8 op count", n_log, 3);
    chk("R8 stop after nack", log_op[2], 4);
    chk("R8 status", sts, 4'h2);
    chk("R8 data0 kept", data0_q, 8'h11);

    // R9 pending device error blocks bus
    @(negedge clk); log_rst = 1'b1; @(negedge clk); log_rst = 1'b0;
    run(3'd0, 8'hA0);
    chk("R9 no ops", n_log, 0);
    chk("R9 status", sts, 4'h2);

    // R8 nack on address of a word read
    prep();
    nack_idx = 0;
    run(3'd3, 8'hA1);
    nack_idx = -1;
    chk("R8 addr nack ops", n_log, 2);
    chk("R8 addr nack data0", data0_q, 8'h11);

    // R10 block read with read flag set, then R11 close
    prep();
    run(3'd6, 8'hA1);
    chk("R10 ops", n_log, 4);
    chk("R10 rw ignored", log_byte[0], 8'hA0);
    chk("R10 offset data1", log_byte[1], 8'h22);
    chk("R10 rep start", log_byte[2], 8'hA1);
    chk("R10 recv ack", log_op[3], 2);
    chk("R10 blk", blk_q, 8'h5A);
    chk("R10 status", sts, 4'hC);
    chk("R10 idle", busy, 0);
    prep();
    chk("R13 host busy protected", sts, 4'h4);
    run(3'd0, 8'hA0);
    chk("R11 ops", n_log, 3);
    chk("R11 stop first", log_op[0], 4);
    chk("R11 then start", log_byte[1], 8'hA0);
    chk("R11 status", sts, 4'h1);

    // R12 start while busy ignored
    prep();
    lat = 6;
    @(negedge clk);
    prot_sel = 3'd3; addr_byte = 8'hA0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    prot_sel = 3'd0; addr_byte = 8'hB1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    lat = 1;
    chk("R12 ops", n_log, 5);
    chk("R12 start byte", log_byte[0], 8'hA0);
    chk("R12 still idle", busy, 0);

    // R13 clear
    prep();
    chk("R13 cleared", sts, 0);

    finish_run();
  end
endmodule